// File: doc/BRIEF.md
# Single-Wire Bus Master Sequencer

This block is the host side of an open-drain, single-wire bus that has a pull-up resistor. It receives one command at a time from a user-side valid/ready handshake: a bus reset with presence detection, a single-bit write, or a single-bit read. It converts the command into the low and released phases on the line, and reports completion with a one-cycle done pulse. A reset returns a presence flag. A read returns the sampled bit. The line is controlled through an output enable that pulls it low. The line level comes back through a two-flop synchronizer. All phase lengths are counted in microseconds from a free-running tick that the block derives from the system clock. Each command begins on a tick boundary, so every phase lasts an exact number of clock cycles.

After each slot the block releases the line for a recovery period before it signals done. This recovery is set by an input in microseconds. It is widened automatically during long unbroken runs of write-0 slots, so that a slave powered parasitically from the line can recharge its internal supply. Byte framing and any higher protocol layers belong to the user.

Top module: `sw_bus_master`

## Requirements
- R1: After reset, `cmd_ready_o` is 1 and `bus_oe_o` and `done_o` are 0.
- R2: A reset command (`cmd_op_i` = 2'b00) drives `bus_oe_o` high for 480 µs from the start of the command. `done_o` pulses 960 µs after the start.
- R3: For a reset command, `result_o` is 1 exactly when the synchronized line is low 550 µs after the start, which is 70 µs after release.
- R4: A write command (`cmd_op_i` = 2'b01) with `cmd_wbit_i` = 1 drives `bus_oe_o` high for 6 µs.
- R5: A write command with `cmd_wbit_i` = 0 drives `bus_oe_o` high for the whole 65 µs slot.
- R6: A read command (`cmd_op_i` = 2'b10 or 2'b11) drives `bus_oe_o` high for 1 µs. `result_o` equals the synchronized line level 15 µs after the start.
- R7: For write and read commands, `done_o` pulses (65 + rec) µs after the start, where rec = max(`rec_us_i`, 1).
- R8: The write-0 slot that completes a run of 64 or more consecutive write-0 commands uses rec = max(`rec_us_i`, 5), and so does every later write-0 slot in the same run. A reset, a write 1 or a read ends the run, and the count starts again from zero.
- R9: A command is accepted only when `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` stays low from acceptance until the done pulse. Each command produces exactly one one-cycle `done_o` pulse, and `cmd_ready_o` is high in the same cycle as that pulse.
- R10: `bus_oe_o` is only high while a command is in progress, and its high phase always begins at the start of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block idle and able to take a command |
| cmd_op_i | input | 2 | 00 reset, 01 write, 1x read |
| cmd_wbit_i | input | 1 | Bit value for a write command |
| rec_us_i | input | 8 | Requested recovery time after a slot, in µs |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 1 | Presence flag (reset) or read bit (read), valid while done_o is high; 0 for a write |
| bus_oe_o | output | 1 | Pull the line low when high |
| bus_i | input | 1 | Raw line level |

## Verification
The bench measures the width of every low pulse and the distance from the start of the command to done, counted in clock cycles. A design with an off-by-one in a phase counter therefore misses by a whole microsecond, and a design whose first microsecond is cut short by tick alignment misses by a fraction of one. It issues a long unbroken run of write-0 slots with the minimum recovery requested. A design that stretches the recovery one slot too early or too late, or that forgets to clear the run after a read or a write 1, shows up as a wrong done time. It also requests a recovery of zero, which a design without the 1 µs floor would finish early. Presence and read data are driven in both polarities, which catches an inverted or mistimed sample. The request is held high past acceptance, which exposes a design that would accept the same request twice.

// File: rtl/sw_bus_pkg.sv
package sw_bus_pkg;
  localparam int US_W = 16;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_READX = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_RUN
  } st_e;

  typedef struct packed {
    logic [US_W-1:0] low_us;
    logic [US_W-1:0] samp_us;
    logic [US_W-1:0] fin_us;
    logic            samp_en;
    logic            invert;
  } plan_t;
endpackage

// File: rtl/sw_bus_tick.sv
module sw_bus_tick #(
  parameter int DIV = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/sw_bus_streak.sv
module sw_bus_streak #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic is_w0_i,
  output logic long_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] SAT = CW'(LIMIT);
  localparam logic [CW-1:0] EDGE = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (acc_i) begin
      if (!is_w0_i) cnt_q <= '0;
      else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  // the slot being accepted is counted toward the run
  assign long_o = is_w0_i && (cnt_q >= EDGE);
endmodule

// File: rtl/sw_bus_timing.sv
module sw_bus_timing
  import sw_bus_pkg::*;
#(
  parameter int T_RST_LOW  = 480,
  parameter int T_RST_WIN  = 480,
  parameter int T_PRES     = 70,
  parameter int T_SLOT     = 65,
  parameter int T_LOW1     = 6,
  parameter int T_LOWR     = 1,
  parameter int T_RDV      = 15,
  parameter int T_REC_MIN  = 1,
  parameter int T_REC_LONG = 5,
  parameter int REC_W      = 8
) (
  input  logic [1:0]       op_i,
  input  logic             wbit_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic             long_i,
  output plan_t            plan_o
);
  logic [US_W-1:0] floor_us;
  logic [US_W-1:0] rec_us;
  logic [US_W-1:0] slot_fin;

  always_comb begin
    floor_us = long_i ? US_W'(T_REC_LONG) : US_W'(T_REC_MIN);
    rec_us   = (US_W'(rec_i) < floor_us) ? floor_us : US_W'(rec_i);
    slot_fin = US_W'(T_SLOT) + rec_us;
    plan_o   = '0;
    unique case (op_e'(op_i))
      OP_RESET: begin
        plan_o.low_us  = US_W'(T_RST_LOW);
        plan_o.samp_us = US_W'(T_RST_LOW + T_PRES);
        plan_o.fin_us  = US_W'(T_RST_LOW + T_RST_WIN);
        plan_o.samp_en = 1'b1;
        plan_o.invert  = 1'b1;
      end
      OP_WRITE: begin
        plan_o.low_us  = wbit_i ? US_W'(T_LOW1) : US_W'(T_SLOT);
        plan_o.fin_us  = slot_fin;
      end
      default: begin
        plan_o.low_us  = US_W'(T_LOWR);
        plan_o.samp_us = US_W'(T_RDV);
        plan_o.fin_us  = slot_fin;
        plan_o.samp_en = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
  import sw_bus_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int T_RST_LOW  = 480,
  parameter int T_RST_WIN  = 480,
  parameter int T_PRES     = 70,
  parameter int T_SLOT     = 65,
  parameter int T_LOW1     = 6,
  parameter int T_LOWR     = 1,
  parameter int T_RDV      = 15,
  parameter int T_REC_MIN  = 1,
  parameter int T_REC_LONG = 5,
  parameter int W0_LIMIT   = 64,
  parameter int REC_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [1:0]       cmd_op_i,
  input  logic             cmd_wbit_i,
  input  logic [REC_W-1:0] rec_us_i,
  output logic             done_o,
  output logic             result_o,
  output logic             bus_oe_o,
  input  logic             bus_i
);
  st_e             st_q;
  plan_t           plan_d, plan_q;
  logic [US_W-1:0] el_q;
  logic            res_q, done_q;
  logic [1:0]      sync_q;
  logic            tick, accept, is_w0, long_rec, rx;

  assign accept = (st_q == ST_IDLE) && cmd_valid_i;
  assign is_w0  = (op_e'(cmd_op_i) == OP_WRITE) && !cmd_wbit_i;

  sw_bus_tick #(.DIV(TICK_DIV)) tick_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  sw_bus_streak #(.LIMIT(W0_LIMIT)) streak_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (accept),
    .is_w0_i(is_w0),
    .long_o (long_rec)
  );

  sw_bus_timing #(
    .T_RST_LOW (T_RST_LOW),
    .T_RST_WIN (T_RST_WIN),
    .T_PRES    (T_PRES),
    .T_SLOT    (T_SLOT),
    .T_LOW1    (T_LOW1),
    .T_LOWR    (T_LOWR),
    .T_RDV     (T_RDV),
    .T_REC_MIN (T_REC_MIN),
    .T_REC_LONG(T_REC_LONG),
    .REC_W     (REC_W)
  ) timing_i (
    .op_i  (cmd_op_i),
    .wbit_i(cmd_wbit_i),
    .rec_i (rec_us_i),
    .long_i(long_rec),
    .plan_o(plan_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else sync_q <= {sync_q[0], bus_i};
  end
  assign rx = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      plan_q <= '0;
      el_q   <= '0;
      res_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          plan_q <= plan_d;
          res_q  <= 1'b0;
          st_q   <= ST_ARM;
        end
        // align the start of the command to a tick
        ST_ARM: if (tick) begin
          el_q <= '0;
          st_q <= ST_RUN;
        end
        ST_RUN: if (tick) begin
          el_q <= el_q + 1'b1;
          if (plan_q.samp_en && (el_q == plan_q.samp_us - 1'b1))
            res_q <= plan_q.invert ? !rx : rx;
          if (el_q == plan_q.fin_us - 1'b1) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign done_o      = done_q;
  assign result_o    = res_q;
  assign bus_oe_o    = (st_q == ST_RUN) && (el_q < plan_q.low_us);
endmodule

// File: rtl/sw_bus_master_chk.sv
module sw_bus_master_chk #(
  parameter int DIV      = 100,
  parameter int L_RST    = 480,
  parameter int L_SLOT   = 65,
  parameter int L_ONE    = 6,
  parameter int L_READ   = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_ready_o,
  input logic done_o,
  input logic bus_oe_o
);
  logic [31:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else if (bus_oe_o) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  a_r10_idle_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !bus_oe_o);

  a_r10_drive_starts_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_oe_o) |-> !cmd_ready_o);

  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_ready_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);

  a_r9_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  a_r9_ready_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_ready_o) |-> done_o);

  // R2 R4 R5 R6: every low pulse has one of the legal widths
  a_r5_low_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_oe_o) |-> (hi_cnt == 32'(L_RST * DIV) || hi_cnt == 32'(L_SLOT * DIV) ||
                         hi_cnt == 32'(L_ONE * DIV) || hi_cnt == 32'(L_READ * DIV)));
endmodule

bind sw_bus_master sw_bus_master_chk #(
  .DIV   (TICK_DIV),
  .L_RST (T_RST_LOW),
  .L_SLOT(T_SLOT),
  .L_ONE (T_LOW1),
  .L_READ(T_LOWR)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid_i),
  .cmd_ready_o(cmd_ready_o),
  .done_o     (done_o),
  .bus_oe_o   (bus_oe_o)
);

// File: tb/sw_bus_master_tb.sv
`timescale 1ns/1ps
module sw_bus_master_tb_top;
  localparam int DIV = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic       cmd_ready_o;
  logic [1:0] cmd_op_i = 2'b00;
  logic       cmd_wbit_i = 1'b0;
  logic [7:0] rec_us_i = 8'd1;
  logic       done_o, result_o, bus_oe_o;
  logic       slave_low = 1'b0;
  logic       bus_i;

  int checks = 0;
  int errors = 0;
  int streak = 0;
  int cycles = 0;

  assign bus_i = !(bus_oe_o || slave_low);

  always #2.5 clk_i = !clk_i;

  sw_bus_master #(.TICK_DIV(DIV)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_ready_o(cmd_ready_o),
    .cmd_op_i   (cmd_op_i),
    .cmd_wbit_i (cmd_wbit_i),
    .rec_us_i   (rec_us_i),
    .done_o     (done_o),
    .result_o   (result_o),
    .bus_oe_o   (bus_oe_o),
    .bus_i      (bus_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int low_us(input logic [1:0] op, input logic wb);
    if (op == 2'b00) return 480;
    if (op == 2'b01) return wb ? 6 : 65;
    return 1;
  endfunction

  function automatic int fin_us(input logic [1:0] op, input int rec, input bit long_rec);
    int fl;
    if (op == 2'b00) return 960;
    fl = long_rec ? 5 : 1;
    return 65 + ((rec < fl) ? fl : rec);
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic wb, input logic slv,
                         input logic [7:0] rec);
    int t, hi, exp_low, exp_fin;
    bit started, busy_ready;
    bit lr;
    string ltag, ftag;
    if (op == 2'b01 && !wb) streak++;
    else streak = 0;
    lr = (streak >= 64);
    exp_low = low_us(op, wb);
    exp_fin = fin_us(op, rec, lr);
    ltag = (op == 2'b00) ? "R2" : (op == 2'b01) ? (wb ? "R4" : "R5") : "R6";
    ftag = (op == 2'b00) ? "R2" : (lr ? "R8" : "R7");
    @(negedge clk_i);
    while (!cmd_ready_o) @(negedge clk_i);
    cmd_op_i = op; cmd_wbit_i = wb; rec_us_i = rec; slave_low = slv;
    cmd_valid_i = 1'b1;
    started = 0; t = 0; hi = 0; busy_ready = 0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk_i);
      if (!started && bus_oe_o) begin
        started = 1;
        cmd_valid_i = 1'b0;
      end
      if (started) t++;
      if (bus_oe_o) hi++;
      if (done_o) break;
      if (n > 0 && cmd_ready_o) busy_ready = 1;
    end
    chk(!busy_ready, "R9", busy_ready, 0);
    chk(done_o == 1'b1, "R9", done_o, 1);
    chk(hi == exp_low * DIV, ltag, hi, exp_low * DIV);
    chk(t - 1 == exp_fin * DIV, ftag, t - 1, exp_fin * DIV);
    if (op == 2'b00) chk(result_o == slv, "R3", result_o, slv);
    else if (op[1]) chk(result_o == !slv, "R6", result_o, !slv);
    slave_low = 1'b0;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R9", done_o, 0);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h51A7_0C3D));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(cmd_ready_o == 1'b1, "R1", cmd_ready_o, 1);
    chk(bus_oe_o == 1'b0, "R1", bus_oe_o, 0);
    chk(done_o == 1'b0, "R1", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(cmd_ready_o == 1'b1, "R1", cmd_ready_o, 1);

    run_cmd(2'b00, 1'b0, 1'b1, 8'd1);  // R3 presence seen
    run_cmd(2'b00, 1'b0, 1'b0, 8'd1);  // R3 no presence
    run_cmd(2'b01, 1'b1, 1'b0, 8'd1);  // R4
    run_cmd(2'b01, 1'b0, 1'b0, 8'd3);  // R5
    run_cmd(2'b10, 1'b0, 1'b0, 8'd0);  // R6 read 1, R7 floor
    run_cmd(2'b11, 1'b0, 1'b1, 8'd2);  // R6 read 0
    run_cmd(2'b01, 1'b1, 1'b0, 8'd0);  // R7 floor

    // R8 long write-0 run, then cleared by read
    for (int i = 0; i < 68; i++) run_cmd(2'b01, 1'b0, 1'b0, (i == 66) ? 8'd7 : 8'd0);
    run_cmd(2'b10, 1'b0, 1'b1, 8'd0);
    run_cmd(2'b01, 1'b0, 1'b0, 8'd1);
    for (int i = 0; i < 63; i++) run_cmd(2'b01, 1'b0, 1'b0, 8'd1);
    run_cmd(2'b01, 1'b1, 1'b0, 8'd1);
    run_cmd(2'b01, 1'b0, 1'b0, 8'd0);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      if (op == 2'b00 && ($urandom % 3) != 0) op = 2'b01;
      run_cmd(op, 1'($urandom), 1'($urandom), 8'($urandom % 8));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule